// File: doc/BRIEF.md
# Receive Ring Page Manager

This block places incoming frames into a circular receive area of local packet memory. The memory is split into 256-byte pages, and a memory address is the page number followed by an 8-bit offset. Software sets a first page and an end page (the end page is one past the last usable page). Software also owns a boundary page that marks how far it has read. The block owns a current page that marks where the next frame will go.

Frame bytes arrive one per cycle on a byte stream. The last byte carries three error flags. The block stores the bytes starting at offset 4 of the current page and moves from page to page, wrapping from the end page back to the first page. After the last byte it goes back to the frame's first page and fills the 4-byte header there: status, the page after the frame, then the byte count low and high. Only then does it move the current page forward.

A frame that would run the current page into the boundary page is abandoned and flagged with a one-cycle overwrite pulse. A stored frame with no error flags raises a one-cycle received pulse. A new frame may begin only after the previous header has finished, which takes four cycles after the last byte.

Top module: `rx_ring_pager`

## Requirements
- R1: While reset is held and right after it, all four ring registers read 0, and memWe, irqRecv and irqOverwrite are 0.
- R2: Host select codes: 0 = first page, 1 = end page, 2 = current page, 3 = boundary. A host write updates the selected register, and hostRdata shows the selected register combinationally.
- R3: A ringInit pulse sets the boundary to the end page minus 1 and the current page to the first page.
- R4: The first byte of a frame is written at address {current page, 0x04}. Each further byte goes to the next offset. After offset 0xFF, writing continues at offset 0 of the following page. The write port is registered, so each write appears one cycle after its input byte.
- R5: The page that follows the page just below the end page is the first page, so the data wraps around the ring.
- R6: After the last data byte, four header writes go to offsets 0, 1, 2 and 3 of the frame's first page, in that order, on consecutive cycles.
- R7: Header byte 0 is the status. Bit 0 is set when all error flags are clear. Bit 1 is the CRC flag (rxErr[0]), bit 2 the alignment flag (rxErr[1]) and bit 3 the overrun flag (rxErr[2]). Bits 7:4 are 0.
- R8: Header byte 1 is the page after the page that holds the last data byte, with wrap. The current page takes this value in the same cycle as the last header write.
- R9: Header bytes 2 and 3 are the low and high bytes of the number of stream bytes in the frame, trailing CRC bytes included.
- R10: The ring is full when a byte at offset 0xFF that is not the last byte needs a next page equal to the boundary, or when the last byte's next page equals the boundary. In that case the frame is dropped: there are no further writes, no header, and the current page does not change. irqOverwrite pulses for one cycle.
- R11: irqRecv pulses for one cycle together with the last header write, and only for frames with all error flags clear. Frames with errors are still stored, but without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostSel | input | 2 | Host register select |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Selected register value |
| ringInit | input | 1 | Pulse that initialises boundary and current page |
| rxValid | input | 1 | Frame byte valid |
| rxData | input | 8 | Frame byte |
| rxLast | input | 1 | Marks the last byte of a frame |
| rxErr | input | 3 | Error flags with the last byte: CRC, alignment, overrun |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory byte address {page, offset} |
| memData | output | 8 | Memory write data |
| irqRecv | output | 1 | Good frame stored pulse |
| irqOverwrite | output | 1 | Ring full, frame dropped pulse |

## Verification
A short frame that fits in one page shows that data starts at offset 4 and that the header fields are right. Longer frames check three things: crossing pages, wrapping from the end page to the first page, and a frame whose last byte lands exactly on offset 0xFF. Two frames run into the boundary: one at its last byte and one in the middle of a page. These separate the end-of-frame full check from the page-crossing full check, and show that dropped frames leave the current page alone. Frames with CRC, alignment and overrun flags show how the status bits are packed and that errored frames give no received pulse.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int PAGE_W    = 8;
  localparam int OFF_W     = 8;
  localparam int ADDR_W    = PAGE_W + OFF_W;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 2 * DATA_W;
  localparam int ERR_W     = 3;
  localparam int HDR_BYTES = 4;
  localparam int HDR_IDX_W = $clog2(HDR_BYTES);
  localparam int SEL_W     = 2;

  localparam logic [SEL_W-1:0] SEL_FIRST = 2'd0;
  localparam logic [SEL_W-1:0] SEL_END   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CURR  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_BNDRY = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_HDR
  } ring_state_t;

  typedef struct packed {
    logic                 wrData;
    logic                 finish;
    logic                 hdrWr;
    logic [HDR_IDX_W-1:0] hdrIdx;
    logic                 commit;
    logic                 overwrite;
  } ring_strobe_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxValid,
  input  logic         rxLast,
  input  logic         pageFull,
  input  logic         offEnd,
  output logic         frameBegin,
  output ring_strobe_t strobe
);
  ring_state_t state, nextState;
  logic [HDR_IDX_W-1:0] hdrIdx;

  assign frameBegin = (state == ST_IDLE) && rxValid;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE, ST_RECV: begin
        if (rxValid) begin
          if ((rxLast || offEnd) && pageFull) begin
            strobe.overwrite = 1'b1;
            nextState = rxLast ? ST_IDLE : ST_DROP;
          end else begin
            strobe.wrData = 1'b1;
            if (rxLast) begin
              strobe.finish = 1'b1;
              nextState = ST_HDR;
            end else begin
              nextState = ST_RECV;
            end
          end
        end
      end
      ST_DROP: begin
        if (rxValid && rxLast) nextState = ST_IDLE;
      end
      ST_HDR: begin
        strobe.hdrWr  = 1'b1;
        strobe.hdrIdx = hdrIdx;
        if (hdrIdx == HDR_IDX_W'(HDR_BYTES - 1)) begin
          strobe.commit = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrIdx <= '0;
    end else begin
      state  <= nextState;
      hdrIdx <= (state == ST_HDR) ? hdrIdx + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [SEL_W-1:0]  hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              ringInit,
  input  logic [DATA_W-1:0] rxData,
  input  logic [ERR_W-1:0]  rxErr,
  input  logic              frameBegin,
  input  ring_strobe_t      strobe,
  output logic              pageFull,
  output logic              offEnd,
  output logic [PAGE_W-1:0] firstPg,
  output logic [PAGE_W-1:0] endPg,
  output logic [PAGE_W-1:0] currPg,
  output logic [PAGE_W-1:0] bndryPg,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irqRecv,
  output logic              irqOverwrite
);
  logic [PAGE_W-1:0] wrPage, hdrPage, linkPg, curPage, followPg;
  logic [OFF_W-1:0]  wrOff, curOff;
  logic [CNT_W-1:0]  byteCnt;
  logic [DATA_W-1:0] statusByte, hdrByte;

  function automatic logic [PAGE_W-1:0] stepPage(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W-1:0] lo,
                                                 input logic [PAGE_W-1:0] hi);
    logic [PAGE_W-1:0] up;
    up = p + 1'b1;
    return (up == hi) ? lo : up;
  endfunction

  assign curPage  = frameBegin ? currPg : wrPage;
  assign curOff   = frameBegin ? OFF_W'(HDR_BYTES) : wrOff;
  assign followPg = stepPage(curPage, firstPg, endPg);
  assign pageFull = (followPg == bndryPg);
  assign offEnd   = (curOff == {OFF_W{1'b1}});

  always_comb begin
    case (strobe.hdrIdx)
      2'd0:    hdrByte = statusByte;
      2'd1:    hdrByte = linkPg;
      2'd2:    hdrByte = byteCnt[DATA_W-1:0];
      default: hdrByte = byteCnt[CNT_W-1:DATA_W];
    endcase
  end

  // ring registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPg <= '0;
      endPg   <= '0;
      currPg  <= '0;
      bndryPg <= '0;
    end else begin
      if (ringInit) begin
        bndryPg <= endPg - 1'b1;
        currPg  <= firstPg;
      end else if (hostWe) begin
        case (hostSel)
          SEL_FIRST: firstPg <= hostWdata;
          SEL_END:   endPg   <= hostWdata;
          SEL_CURR:  currPg  <= hostWdata;
          default:   bndryPg <= hostWdata;
        endcase
      end
      if (strobe.commit) currPg <= linkPg;
    end
  end

  // frame tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPage     <= '0;
      wrOff      <= '0;
      hdrPage    <= '0;
      byteCnt    <= '0;
      linkPg     <= '0;
      statusByte <= '0;
    end else begin
      if (frameBegin) hdrPage <= currPg;
      if (strobe.wrData) begin
        byteCnt <= (frameBegin ? '0 : byteCnt) + 1'b1;
        if (offEnd) begin
          wrPage <= followPg;
          wrOff  <= '0;
        end else begin
          wrPage <= curPage;
          wrOff  <= curOff + 1'b1;
        end
      end
      if (strobe.finish) begin
        linkPg     <= followPg;
        statusByte <= {{(DATA_W-ERR_W-1){1'b0}}, rxErr, ~|rxErr};
      end
    end
  end

  // memory port and pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe        <= 1'b0;
      memAddr      <= '0;
      memData      <= '0;
      irqRecv      <= 1'b0;
      irqOverwrite <= 1'b0;
    end else begin
      memWe        <= strobe.wrData | strobe.hdrWr;
      irqRecv      <= strobe.commit & statusByte[0];
      irqOverwrite <= strobe.overwrite;
      if (strobe.hdrWr) begin
        memAddr <= {hdrPage, {(OFF_W-HDR_IDX_W){1'b0}}, strobe.hdrIdx};
        memData <= hdrByte;
      end else begin
        memAddr <= {curPage, curOff};
        memData <= rxData;
      end
    end
  end
endmodule

// File: rtl/rx_ring_pager.sv
module rx_ring_pager
  import rx_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [SEL_W-1:0]  hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              ringInit,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxLast,
  input  logic [ERR_W-1:0]  rxErr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irqRecv,
  output logic              irqOverwrite
);
  ring_strobe_t      strobe;
  logic              frameBegin, pageFull, offEnd;
  logic [PAGE_W-1:0] firstPg, endPg, currPg, bndryPg;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast),
    .pageFull(pageFull), .offEnd(offEnd),
    .frameBegin(frameBegin), .strobe(strobe)
  );

  rx_ring_dp u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .ringInit(ringInit), .rxData(rxData),
    .rxErr(rxErr), .frameBegin(frameBegin), .strobe(strobe),
    .pageFull(pageFull), .offEnd(offEnd),
    .firstPg(firstPg), .endPg(endPg), .currPg(currPg), .bndryPg(bndryPg),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .irqRecv(irqRecv), .irqOverwrite(irqOverwrite)
  );

  always_comb begin
    case (hostSel)
      SEL_FIRST: hostRdata = firstPg;
      SEL_END:   hostRdata = endPg;
      SEL_CURR:  hostRdata = currPg;
      default:   hostRdata = bndryPg;
    endcase
  end
endmodule

// File: rtl/rx_ring_checker.sv
module rx_ring_checker
  import rx_ring_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irqRecv,
  input logic              irqOverwrite,
  input logic [PAGE_W-1:0] firstPg,
  input logic [PAGE_W-1:0] endPg,
  input logic [PAGE_W-1:0] currPg
);
  AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && firstPg < endPg) |->
      (memAddr[ADDR_W-1:OFF_W] >= firstPg && memAddr[ADDR_W-1:OFF_W] < endPg)); // R5

  AST_CURR_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    (irqRecv && firstPg < endPg) |-> (currPg >= firstPg && currPg < endPg)); // R8

  AST_RECV_ON_HDR_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    irqRecv |-> (memWe && memAddr[OFF_W-1:0] == OFF_W'(HDR_BYTES - 1))); // R6

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    irqOverwrite |-> !memWe); // R10

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqRecv && irqOverwrite)); // R11
endmodule

bind rx_ring_pager rx_ring_checker u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr),
  .irqRecv(irqRecv), .irqOverwrite(irqOverwrite),
  .firstPg(firstPg), .endPg(endPg), .currPg(currPg)
);

// File: tb/sim_rx_ring_pager.sv
`timescale 1ns/1ps
module sim_rx_ring_pager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        ringInit = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxLast = 1'b0;
  logic [2:0]  rxErr = '0;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic        irqRecv, irqOverwrite;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
  } exp_t;

  exp_t q[$];
  string kindTag[5] = '{"R4", "R7", "R8", "R9", "R5"};
  int checks = 0, fails = 0;
  int gotRecv = 0, gotOvw = 0, expRecv = 0, expOvw = 0;
  logic [7:0] mFirst, mEnd, mCurr, mBnd;

  always #4 clk = ~clk;

  rx_ring_pager u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ringInit(ringInit),
    .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast), .rxErr(rxErr),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .irqRecv(irqRecv), .irqOverwrite(irqOverwrite)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stepPg(input logic [7:0] p);
    return (p + 8'd1 == mEnd) ? mFirst : p + 8'd1;
  endfunction

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rstN) begin
      if (irqRecv) gotRecv++;
      if (irqOverwrite) gotOvw++;
      if (memWe) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected write", int'({memAddr, memData}), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({memAddr, memData} == {e.addr, e.data}, kindTag[e.kind],
                int'({memAddr, memData}), int'({e.addr, e.data}));
        end
      end
    end
  end

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] val);
    hostWe = 1'b1; hostSel = sel; hostWdata = val;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [7:0] val);
    hostSel = sel; #1;
    val = hostRdata;
  endtask

  task automatic setBoundary(input logic [7:0] b);
    hostWrite(2'd3, b);
    mBnd = b;
  endtask

  task automatic sendFrame(input int len, input logic [2:0] err);
    logic [7:0] page, off, nxt, first, rd;
    logic drop, wrapped;
    exp_t e;
    page = mCurr; off = 8'd4; first = mCurr; drop = 1'b0; wrapped = 1'b0; nxt = '0;
    for (int i = 0; i < len; i++) begin
      logic last;
      last = (i == len - 1);
      if (!drop) begin
        if ((off == 8'hFF || last) && stepPg(page) == mBnd) begin
          drop = 1'b1;
          expOvw++;
        end else begin
          e.kind = wrapped ? 3'd4 : 3'd0;
          e.addr = {page, off};
          e.data = 8'((i * 7 + len) & 255);
          q.push_back(e);
          if (last) nxt = stepPg(page);
          if (off == 8'hFF) begin
            if (page + 8'd1 == mEnd) wrapped = 1'b1;
            page = stepPg(page);
            off = 8'd0;
          end else begin
            off = off + 8'd1;
          end
        end
      end
    end
    if (!drop) begin
      e.kind = 3'd1; e.addr = {first, 8'd0}; e.data = {4'd0, err, ~|err}; q.push_back(e);
      e.kind = 3'd2; e.addr = {first, 8'd1}; e.data = nxt;                 q.push_back(e);
      e.kind = 3'd3; e.addr = {first, 8'd2}; e.data = 8'(len);             q.push_back(e);
      e.kind = 3'd3; e.addr = {first, 8'd3}; e.data = 8'(len >> 8);       q.push_back(e);
      mCurr = nxt;
      if (err == 3'd0) expRecv++;
    end
    for (int i = 0; i < len; i++) begin
      rxValid = 1'b1;
      rxData  = 8'((i * 7 + len) & 255);
      rxLast  = (i == len - 1);
      rxErr   = (i == len - 1) ? err : 3'd0;
      @(posedge clk); #1;
    end
    rxValid = 1'b0; rxLast = 1'b0; rxErr = '0;
    repeat (10) @(posedge clk);
    #1;
    check(q.size() == 0, "R6 all expected writes seen", q.size(), 0);
    check(gotRecv == expRecv, "R11 received pulses", gotRecv, expRecv);
    check(gotOvw == expOvw, "R10 overwrite pulses", gotOvw, expOvw);
    hostRead(2'd2, rd);
    check(rd == mCurr, "R8 current page after frame", rd, mCurr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!memWe && !irqRecv && !irqOverwrite, "R1 outputs in reset",
          int'({memWe, irqRecv, irqOverwrite}), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    for (int s = 0; s < 4; s++) begin
      hostRead(2'(s), rd);
      check(rd == 8'd0, "R1 register reset value", rd, 0);
    end

    hostWrite(2'd0, 8'h10);
    hostWrite(2'd1, 8'h14);
    hostRead(2'd0, rd); check(rd == 8'h10, "R2 first page readback", rd, 8'h10);
    hostRead(2'd1, rd); check(rd == 8'h14, "R2 end page readback", rd, 8'h14);
    hostWrite(2'd3, 8'h55);
    hostRead(2'd3, rd); check(rd == 8'h55, "R2 boundary readback", rd, 8'h55);
    mFirst = 8'h10; mEnd = 8'h14;

    ringInit = 1'b1; @(posedge clk); #1; ringInit = 1'b0;
    hostRead(2'd3, rd); check(rd == 8'h13, "R3 boundary after init", rd, 8'h13);
    hostRead(2'd2, rd); check(rd == 8'h10, "R3 current after init", rd, 8'h10);
    mCurr = 8'h10; mBnd = 8'h13;

    sendFrame(64, 3'b000);    // R4 short good frame
    setBoundary(8'h10);
    sendFrame(300, 3'b001);   // R7 CRC flag, crosses a page
    setBoundary(8'h12);
    sendFrame(600, 3'b000);   // R10 full at last byte, after R5 wrap
    sendFrame(500, 3'b000);   // R5 wrap, stored
    sendFrame(400, 3'b000);   // R10 full at page crossing
    setBoundary(8'h10);
    sendFrame(252, 3'b110);   // R9 ends exactly at offset 0xFF, R7 align+overrun

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule